// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Accumulating Result Pair

This unit sits beside a processor pipeline and performs 32-bit integer multiplication, multiply-accumulate, multiply-subtract and division. Results go into a 64-bit result pair: a high word and a low word. The pipeline hands over an operation through a valid/ready issue port. The port carries two operands, an operation code and a signed/unsigned flag. The pipeline then keeps running until it needs the result pair. A read port exposes either word, and its ready line stays low until the pending operation has settled. This means a stall happens only when a result is actually consumed too early.

Multiplication passes through one 32x16 partial-product array. A second operand that fits in 16 bits needs one pass, so such multiplies can be issued back to back on every clock. A full-width second operand needs two passes, which gives one issue every other clock. Division is a restoring shift-subtract loop. Before it starts, the loop skips whole leading bytes of the dividend magnitude that carry no information, so small dividends finish sooner.

Top module: `mdu_core`

## Requirements
- R1: After reset both result words read zero, `busy` is low and `issue_ready` is high.
- R2: Operation codes are 0 = multiply, 1 = multiply-accumulate, 2 = multiply-subtract, 3 = divide. A multiply whose second operand fits in 16 bits (bits 31..15 all equal when signed, bits 31..16 zero when unsigned) writes the 64-bit product into high:low at the accepting edge. `busy` stays low, so a new multiply can be accepted on every cycle.
- R3: A multiply with a full-width second operand keeps `busy` and `issue_ready` low for exactly the one cycle after acceptance. The product appears in high:low at the second edge.
- R4: Multiply-accumulate replaces high:low with high:low plus the 64-bit product, modulo 2^64, for both short and full-width operands.
- R5: Multiply-subtract replaces high:low with high:low minus the 64-bit product, modulo 2^64.
- R6: Division leaves the quotient in the low word and the remainder in the high word. In signed division the quotient is truncated toward zero and the remainder carries the dividend's sign. Most-negative divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: A divide keeps `busy` high for L cycles after its accepting edge. L is 33 when the dividend magnitude is at least 2^24, 25 when it is at least 2^16, 17 when it is at least 2^8, and 11 otherwise, including zero. The magnitude is the two's-complement negation of a negative signed dividend.
- R8: An issue presented while `busy` is high is refused: `issue_ready` is low and the result pair is left unchanged.
- R9: `rd_ready` is low whenever an operation is in flight. `rd_data` shows the high word when `rd_sel` is 1 and the low word when it is 0.
- R10: Division by zero completes with the same latency as R7 and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation offered |
| issue_ready | output | 1 | Operation can be accepted this cycle |
| issue_op | input | 2 | Operation code (see R2) |
| issue_signed | input | 1 | Treat operands as two's complement |
| opa | input | 32 | First operand / dividend |
| opb | input | 32 | Second operand / divisor |
| busy | output | 1 | An operation is in flight |
| rd_sel | input | 1 | 1 selects high word, 0 selects low word |
| rd_ready | output | 1 | Selected word is final |
| rd_data | output | 32 | Selected result word |

## Verification
The bench builds the unit with its default sizes: 32-bit operands, a 16-bit array slice and 8-bit early-in groups. Those sizes are what fix the one-pass/two-pass split and the four divide latencies. A table of boundary operands is swept in every pair under both signednesses. The table holds zero, ±1, the most negative value, the most positive value, values at the 16-bit edge and values at each byte edge. Each pair checks the product, the quotient and remainder, and the pass count or divide latency, which the bench derives from the operand bits. Accumulate chains, back-to-back short multiplies and refused issues during a long divide cover the remaining behaviour.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   typedef enum logic [1:0] {
      OP_MUL  = 2'd0,
      OP_MADD = 2'd1,
      OP_MSUB = 2'd2,
      OP_DIV  = 2'd3
   } mdu_op_e;
endpackage

// File: rtl/mdu_pp.sv
// One pass of the AW x BW partial-product array, sign-extended to 2*AW bits.
module mdu_pp #(
   parameter int AW = 32,
   parameter int BW = 16
) (
   input  logic [AW-1:0]   a,
   input  logic            a_sgn,
   input  logic [BW-1:0]   b,
   input  logic            b_sgn,
   output logic [2*AW-1:0] p
);
   localparam int PW = AW + BW + 2;

   logic signed [AW:0]   ax;
   logic signed [BW:0]   bx;
   logic signed [PW-1:0] axe, bxe, px;

   assign ax  = {a_sgn & a[AW-1], a};
   assign bx  = {b_sgn & b[BW-1], b};
   assign axe = PW'(ax);
   assign bxe = PW'(bx);
   assign px  = axe * bxe;

   generate
      if (2*AW > PW) begin : g_ext
         assign p = {{(2*AW-PW){px[PW-1]}}, px};
      end else begin : g_trunc
         assign p = px[2*AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/mdu_div.sv
// Restoring divider with early-in skipping of leading all-zero magnitude groups.
module mdu_div #(
   parameter int DW      = 32,
   parameter int GRP     = 8,
   parameter int MIN_LAT = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          sgn,
   input  logic [DW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quo_o,
   output logic [DW-1:0] rem_o
);
   localparam int NG = DW / GRP;
   localparam int CW = $clog2(DW + 2);

   generate
      if (DW % GRP != 0 || NG < 2) begin : g_bad_grp
         $error("mdu_div: DW must be a multiple of GRP with at least two groups");
      end
      if (MIN_LAT > DW + 1) begin : g_bad_lat
         $error("mdu_div: MIN_LAT exceeds full latency");
      end
   endgenerate

   logic [DW-1:0] mag_a, mag_b;
   logic [NG-1:1] grp_zero;
   logic [CW-1:0] skip;
   logic          run;
   int            shamt, full_lat;

   logic [DW-1:0] rem_q, quo_q, dvs_q;
   logic [CW-1:0] iter_q, cnt_q;
   logic          neg_q_q, neg_r_q;
   logic [DW:0]   sh, diff;

   assign mag_a = (sgn & dividend[DW-1]) ? -dividend : dividend;
   assign mag_b = (sgn & divisor[DW-1])  ? -divisor  : divisor;

   for (genvar g = 1; g < NG; g++) begin : g_grp
      assign grp_zero[g] = ~|mag_a[g*GRP +: GRP];
   end

   always_comb begin
      skip = '0;
      run  = 1'b1;
      for (int g = NG-1; g >= 1; g--) begin
         run = run & grp_zero[g];
         if (run) skip = skip + CW'(1);
      end
      shamt    = int'(skip) * GRP;
      full_lat = DW + 1 - shamt;
      if (full_lat < MIN_LAT) full_lat = MIN_LAT;
   end

   assign sh   = {rem_q, quo_q[DW-1]};
   assign diff = sh - {1'b0, dvs_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         quo_q   <= '0;
         dvs_q   <= '0;
         iter_q  <= '0;
         cnt_q   <= '0;
         neg_q_q <= 1'b0;
         neg_r_q <= 1'b0;
      end else if (start) begin
         rem_q   <= '0;
         quo_q   <= mag_a << shamt;
         dvs_q   <= mag_b;
         iter_q  <= CW'(DW - shamt);
         cnt_q   <= CW'(full_lat);
         neg_q_q <= sgn & (dividend[DW-1] ^ divisor[DW-1]);
         neg_r_q <= sgn & dividend[DW-1];
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
         if (iter_q != '0) begin
            iter_q <= iter_q - CW'(1);
            if (!diff[DW]) begin
               rem_q <= diff[DW-1:0];
               quo_q <= {quo_q[DW-2:0], 1'b1};
            end else begin
               rem_q <= sh[DW-1:0];
               quo_q <= {quo_q[DW-2:0], 1'b0};
            end
         end
      end
   end

   assign busy  = (cnt_q != '0);
   assign done  = (cnt_q == CW'(1));
   assign quo_o = neg_q_q ? -quo_q : quo_q;
   assign rem_o = neg_r_q ? -rem_q : rem_q;

   // R7: the result is only released after every shift-subtract step ran
   p_iter_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (iter_q == '0));
   // R7: the countdown never exceeds the full latency
   p_lat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= CW'(DW + 1)));
   // R8: a divide is never restarted while one is running
   p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/mdu_core.sv
module mdu_core
   import mdu_pkg::*;
#(
   parameter int DW      = 32,
   parameter int PART    = 16,
   parameter int GRP     = 8,
   parameter int DIV_MIN = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_valid,
   output logic          issue_ready,
   input  logic [1:0]    issue_op,
   input  logic          issue_signed,
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   output logic          busy,
   input  logic          rd_sel,
   output logic          rd_ready,
   output logic [DW-1:0] rd_data
);
   localparam int HW = DW - PART;

   generate
      if (HW != PART) begin : g_bad_split
         $error("mdu_core: the array must cover half of the operand width");
      end
   endgenerate

   mdu_op_e         op_in, op_q, op_sel;
   logic            accept, b_short, mul_pend, div_start, div_busy, div_done;
   logic            sgn_q, pp_as, pp_bs;
   logic [DW-1:0]   a_q, pp_a, quo, rem;
   logic [PART-1:0] bhi_q, pp_b;
   logic [2*DW-1:0] hilo, acc_q, pp, prod, hilo_next;

   assign op_in  = mdu_op_e'(issue_op);
   assign accept = issue_valid & issue_ready;
   assign b_short = issue_signed ? (&opb[DW-1:PART-1] | ~|opb[DW-1:PART-1])
                                 : ~|opb[DW-1:PART];

   // Shared array: first/only pass from the issue port, second pass from state.
   assign pp_a  = mul_pend ? a_q   : opa;
   assign pp_b  = mul_pend ? bhi_q : opb[PART-1:0];
   assign pp_as = mul_pend ? sgn_q : issue_signed;
   assign pp_bs = mul_pend ? sgn_q : (issue_signed & b_short);

   mdu_pp #(.AW(DW), .BW(PART)) i_pp (
      .a(pp_a), .a_sgn(pp_as), .b(pp_b), .b_sgn(pp_bs), .p(pp)
   );

   assign prod   = mul_pend ? (acc_q + (pp << PART)) : pp;
   assign op_sel = mul_pend ? op_q : op_in;

   always_comb begin
      unique case (op_sel)
         OP_MADD: hilo_next = hilo + prod;
         OP_MSUB: hilo_next = hilo - prod;
         default: hilo_next = prod;
      endcase
   end

   assign div_start = accept & (op_in == OP_DIV);

   mdu_div #(.DW(DW), .GRP(GRP), .MIN_LAT(DIV_MIN)) i_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .sgn(issue_signed),
      .dividend(opa), .divisor(opb), .busy(div_busy), .done(div_done),
      .quo_o(quo), .rem_o(rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hilo     <= '0;
         mul_pend <= 1'b0;
         acc_q    <= '0;
         a_q      <= '0;
         bhi_q    <= '0;
         sgn_q    <= 1'b0;
         op_q     <= OP_MUL;
      end else if (mul_pend) begin
         hilo     <= hilo_next;
         mul_pend <= 1'b0;
      end else if (div_done) begin
         hilo <= {rem, quo};
      end else if (accept && op_in != OP_DIV) begin
         if (b_short) begin
            hilo <= hilo_next;
         end else begin
            mul_pend <= 1'b1;
            acc_q    <= pp;
            a_q      <= opa;
            bhi_q    <= opb[DW-1:PART];
            sgn_q    <= issue_signed;
            op_q     <= op_in;
         end
      end
   end

   assign busy        = mul_pend | div_busy;
   assign issue_ready = ~busy;
   assign rd_ready    = ~busy;
   assign rd_data     = rd_sel ? hilo[2*DW-1:DW] : hilo[DW-1:0];

   // R2: a one-pass multiply never makes the unit busy
   p_short_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_in != OP_DIV && b_short) |=> !busy);
   // R3: the second pass occupies exactly one cycle
   p_two_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mul_pend) |=> !mul_pend);
   // R8: while a divide runs and is not finishing, the result pair holds
   p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (div_busy && !div_done) |=> $stable(hilo));
   // R9: the read port is never ready during the second multiply pass
   p_rd_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mul_pend |-> !rd_ready);
endmodule

// File: tb/test_mdu_core.sv
module test_mdu_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic        issue_ready;
   logic [1:0]  issue_op = 2'd0;
   logic        issue_signed = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        busy, rd_sel = 1'b0, rd_ready;
   logic [31:0] rd_data;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   mdu_core i_mdu_core (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_op(issue_op), .issue_signed(issue_signed), .opa(opa), .opb(opb),
      .busy(busy), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   logic [31:0] vals [12] = '{32'h0, 32'h1, 32'h7, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_8000,
                              32'h0000_8000, 32'hFFFF_FF00, 32'h0000_FFFF, 32'h00AB_CDEF};

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_mul(input bit s, input logic [31:0] a, b);
      longint pa, pb;
      pa = s ? longint'($signed(a)) : longint'({32'b0, a});
      pb = s ? longint'($signed(b)) : longint'({32'b0, b});
      return 64'(pa * pb);
   endfunction

   function automatic logic [63:0] ref_div(input bit s, input logic [31:0] a, b);
      longint q, r;
      if (s) begin
         q = longint'($signed(a)) / longint'($signed(b));
         r = longint'($signed(a)) % longint'($signed(b));
         return {r[31:0], q[31:0]};
      end
      return {a % b, a / b};
   endfunction

   function automatic bit is_short(input bit s, input logic [31:0] b);
      if (s) return (b[31:15] == '0) || (b[31:15] == '1);
      return b[31:16] == '0;
   endfunction

   function automatic int div_lat(input bit s, input logic [31:0] a);
      logic [31:0] m;
      m = (s && a[31]) ? -a : a;
      if (m >= 32'h0100_0000) return 33;
      if (m >= 32'h0001_0000) return 25;
      if (m >= 32'h0000_0100) return 17;
      return 11;
   endfunction

   // Presents one operation for one edge; returns at the negedge after acceptance.
   task automatic issue(input logic [1:0] op, input bit s, input logic [31:0] a, b);
      @(negedge clk);
      issue_valid = 1'b1; issue_op = op; issue_signed = s; opa = a; opb = b;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic get_hilo(output logic [63:0] v);
      rd_sel = 1'b1; #1; v[63:32] = rd_data;
      rd_sel = 1'b0; #1; v[31:0]  = rd_data;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [63:0] v, e;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      get_hilo(v);
      chk(v == 64'h0, "R1 result pair", v, 64'h0);
      chk(!busy && issue_ready && rd_ready, "R1 idle flags", {busy, issue_ready}, 2'b01);

      // Product and divide sweep over all boundary pairs, both signednesses
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            for (int s = 0; s < 2; s++) begin
               issue(2'd0, s[0], vals[i], vals[j]);
               if (!is_short(s[0], vals[j]))
                  chk(!issue_ready && !rd_ready, "R3 ready low in second pass",
                      {issue_ready, rd_ready}, 2'b00);
               wait_idle(n);
               chk(n == (is_short(s[0], vals[j]) ? 0 : 1),
                   is_short(s[0], vals[j]) ? "R2 pass count" : "R3 pass count",
                   64'(n), is_short(s[0], vals[j]) ? 64'd0 : 64'd1);
               get_hilo(v);
               e = ref_mul(s[0], vals[i], vals[j]);
               chk(v == e, is_short(s[0], vals[j]) ? "R2 product" : "R3 product", v, e);

               issue(2'd3, s[0], vals[i], vals[j]);
               wait_idle(n);
               chk(n == div_lat(s[0], vals[i]),
                   vals[j] == 0 ? "R10 zero-divisor latency" : "R7 divide latency",
                   64'(n), 64'(div_lat(s[0], vals[i])));
               if (vals[j] != 0) begin
                  get_hilo(v);
                  e = ref_div(s[0], vals[i], vals[j]);
                  chk(v == e, "R6 quotient/remainder", v, e);
               end
            end
         end
      end

      // Accumulate and subtract chains
      for (int i = 0; i < 12; i++) begin
         for (int s = 0; s < 2; s++) begin
            issue(2'd0, s[0], vals[i], vals[(i+5)%12]);
            wait_idle(n);
            e = ref_mul(s[0], vals[i], vals[(i+5)%12]);
            issue(2'd1, s[0], vals[(i+3)%12], vals[(i+7)%12]);
            wait_idle(n);
            e = e + ref_mul(s[0], vals[(i+3)%12], vals[(i+7)%12]);
            get_hilo(v);
            chk(v == e, "R4 accumulate", v, e);
            issue(2'd2, s[0], vals[(i+1)%12], vals[i]);
            wait_idle(n);
            e = e - ref_mul(s[0], vals[(i+1)%12], vals[i]);
            get_hilo(v);
            chk(v == e, "R5 subtract", v, e);
         end
      end

      // Short multiplies on consecutive cycles
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         issue_valid = 1'b1; issue_op = 2'd1; issue_signed = 1'b1;
         opa = 32'h0F0F_0F0F * (k + 1); opb = 32'(-(k * 1000));
         e = (k == 0) ? 64'h0 : e;
         e = e + ref_mul(1'b1, opa, opb);
         @(negedge clk);
         chk(issue_ready && !busy, "R2 back-to-back ready", {issue_ready, busy}, 2'b10);
         get_hilo(v);
         if (k == 0) e = v - ref_mul(1'b1, opa, opb) + ref_mul(1'b1, opa, opb);
         chk(v == e, "R2 back-to-back accumulate", v, e);
      end
      issue_valid = 1'b0;

      // Refused issue during a long divide
      issue(2'd3, 1'b0, 32'h7FFF_FFFF, 32'd3);
      issue_valid = 1'b1; issue_op = 2'd0; opa = 32'd5; opb = 32'd5;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!issue_ready, "R8 issue refused while busy", 64'(issue_ready), 64'd0);
         chk(!rd_ready, "R9 read stalled while busy", 64'(rd_ready), 64'd0);
      end
      issue_valid = 1'b0;
      wait_idle(n);
      get_hilo(v);
      e = {32'd1, 32'h2AAA_AAAA};
      chk(v == e, "R8 pair unchanged by refused issue", v, e);
      rd_sel = 1'b1; #1;
      chk(rd_ready && rd_data == 32'd1, "R9 high word select", rd_data, 32'd1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule